// File: doc/BRIEF.md
# Rotating Scanout Address Generator

This block produces the stream of byte addresses that a display read engine uses to fetch 16-bit pixels from a framebuffer and send them to a 240-pixel-wide, 320-line panel. A frame consists of 329 line entries. The first 9 are blanking lines and the remaining 320 are visible lines. Every line entry yields 240 addresses, and each address points at a 2-byte pixel.

The block has two scan orders. In portrait order the buffer is read straight through from its base address, 2 bytes at a time, with no break at line boundaries. In landscape order the stored picture is 320 pixels wide and 240 rows tall. It is read down its columns so that it appears rotated on the panel. Each visible output line starts at a column offset that falls as the line number rises, and it steps by a full stored row (640 bytes) per pixel. Every blanking line starts at the buffer base.

Addresses leave the block through a valid/ready handshake, and each accepted transfer advances the scan by one pixel. A start-of-frame marker and an end-of-line marker travel with the matching addresses. The scan order and the base address are captured only when a frame begins.

Top module: `scan_addr_gen`

## Requirements
- R1: While reset is held, `addr_valid_o` is 0. On the first clock edge after reset is released, the block captures `base_i` and `landscape_i`. From then on `addr_valid_o` stays 1, and the first address presented equals `base_i`, with `sof_o` set.
- R2: Each line entry presents exactly 240 addresses. `eol_o` is 1 only with the 240th address, which is pixel index 239.
- R3: When `landscape_i` was 0 at the frame start (portrait), the address for line L (0..328) and pixel P (0..239) is base + 2*(240*L + P). The sequence is therefore linear across all 329 lines, and visible line 9 starts 240*8*2 bytes past line 1.
- R4: In landscape order (`landscape_i` was 1 at the frame start), each of blanking lines 0 to 8 starts at the base address, and its pixels step by 640 bytes.
- R5: In landscape order, visible line L (9..328) starts at base + 2*(328 - L), and pixel P of that line is at that start + 640*P.
- R6: After pixel 239 of line 328 is accepted, the scan wraps to line 0, pixel 0, at the newly captured base address. This repeats without end.
- R7: `landscape_i` and `base_i` are sampled only on the transfer that wraps the frame and on the first edge after reset. Changes to them during a frame do not affect any address of that frame.
- R8: While `addr_valid_o` is 1 and `addr_ready_i` is 0, the address and both markers hold their values. Each cycle with both high advances the scan by exactly one pixel.
- R9: `sof_o` is 1 only with the address of line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | ADDR_W | Buffer base byte address, captured at frame start |
| landscape_i | input | 1 | 1 selects the rotated column-wise scan, 0 the linear scan; captured at frame start |
| addr_ready_i | input | 1 | Consumer accepts the current address |
| addr_valid_o | output | 1 | Address output is valid |
| addr_o | output | ADDR_W | Pixel byte address |
| sof_o | output | 1 | Marks the first address of a frame |
| eol_o | output | 1 | Marks the last address of a line entry |

## Verification
Each address is built from the previous one plus a stride, or from a freshly computed line start. An off-by-one in the pixel or line counter therefore shows up within one line as a misplaced `eol_o`, and as a wrong line-start address on the very next transfer. A wrong capture of the scan order or base appears as a wrong address on the first transfer of the following frame. A counter that slips under back-pressure appears as an address that moves while `addr_ready_i` is low. The bench compares every presented address and marker against a model built from the line and pixel formulas, across full frames in both orders, including stalls and inputs that change in the middle of a frame.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic {
        SCAN_PORTRAIT  = 1'b0,
        SCAN_LANDSCAPE = 1'b1
    } scan_mode_e;
endpackage

// File: rtl/scan_step.sv
// Pixel/line position successor and boundary flags.
module scan_step #(
    parameter int PIX_PER_LINE = 240,
    parameter int TOTAL_LINES  = 329,
    parameter int PIX_W        = 8,
    parameter int LINE_W       = 9
) (
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [LINE_W-1:0] line_i,
    output logic [PIX_W-1:0]  pix_nxt_o,
    output logic [LINE_W-1:0] line_nxt_o,
    output logic              last_pix_o,
    output logic              frame_end_o
);
    localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(PIX_PER_LINE - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(TOTAL_LINES - 1);

    always_comb begin
        last_pix_o  = (pix_i == PIX_LAST);
        frame_end_o = last_pix_o && (line_i == LINE_LAST);
        pix_nxt_o   = last_pix_o ? '0 : pix_i + PIX_W'(1);
        line_nxt_o  = frame_end_o ? '0 : line_i + LINE_W'(1);
    end
endmodule

// File: rtl/scan_line_start.sv
// Byte offset of a line's first pixel and per-pixel stride for a scan order.
module scan_line_start
    import scan_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int PIX_PER_LINE  = 240,
    parameter int BLANK_LINES   = 9,
    parameter int TOTAL_LINES   = 329,
    parameter int BYTES_PER_PIX = 2,
    parameter int LINE_W        = 9
) (
    input  logic [LINE_W-1:0] line_i,
    input  scan_mode_e        mode_i,
    output logic [ADDR_W-1:0] offset_o,
    output logic [ADDR_W-1:0] stride_o
);
    localparam int VIS_LINES = TOTAL_LINES - BLANK_LINES;
    localparam logic [ADDR_W-1:0] ROW_BYTES  = ADDR_W'(PIX_PER_LINE * BYTES_PER_PIX);
    localparam logic [ADDR_W-1:0] COL_STRIDE = ADDR_W'(VIS_LINES * BYTES_PER_PIX);
    localparam logic [ADDR_W-1:0] PIX_BYTES  = ADDR_W'(BYTES_PER_PIX);
    localparam logic [LINE_W-1:0] LINE_LAST  = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] FIRST_VIS  = LINE_W'(BLANK_LINES);

    logic [LINE_W-1:0] col_idx;

    always_comb begin
        col_idx = LINE_LAST - line_i;
        if (mode_i == SCAN_LANDSCAPE) begin
            stride_o = COL_STRIDE;
            if (line_i < FIRST_VIS) begin
                offset_o = '0;
            end else begin
                offset_o = ADDR_W'(col_idx) * PIX_BYTES;
            end
        end else begin
            stride_o = PIX_BYTES;
            offset_o = ADDR_W'(line_i) * ROW_BYTES;
        end
    end
endmodule

// File: rtl/scan_addr_gen.sv
// Scanout address generator: linear or rotated (column-wise) framebuffer read order.
module scan_addr_gen
    import scan_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int PIX_PER_LINE  = 240,
    parameter int VIS_LINES     = 320,
    parameter int BLANK_LINES   = 9,
    parameter int BYTES_PER_PIX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              landscape_i,
    input  logic              addr_ready_i,
    output logic              addr_valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sof_o,
    output logic              eol_o
);
    localparam int TOTAL_LINES = VIS_LINES + BLANK_LINES;
    localparam int PIX_W       = $clog2(PIX_PER_LINE);
    localparam int LINE_W      = $clog2(TOTAL_LINES);

    typedef struct packed {
        logic              run;
        scan_mode_e        mode;
        logic [ADDR_W-1:0] base;
        logic [LINE_W-1:0] line;
        logic [PIX_W-1:0]  pix;
        logic [ADDR_W-1:0] addr;
    } scan_state_t;

    scan_state_t s_d, s_q;

    logic [PIX_W-1:0]  pix_nxt;
    logic [LINE_W-1:0] line_nxt;
    logic              last_pix;
    logic              frame_end;
    logic [ADDR_W-1:0] nxt_offset;
    logic [ADDR_W-1:0] stride;
    scan_mode_e        mode_in;

    scan_step #(
        .PIX_PER_LINE (PIX_PER_LINE),
        .TOTAL_LINES  (TOTAL_LINES),
        .PIX_W        (PIX_W),
        .LINE_W       (LINE_W)
    ) u_step (
        .pix_i       (s_q.pix),
        .line_i      (s_q.line),
        .pix_nxt_o   (pix_nxt),
        .line_nxt_o  (line_nxt),
        .last_pix_o  (last_pix),
        .frame_end_o (frame_end)
    );

    // Start of the line that follows the current one, in the frame's scan order.
    scan_line_start #(
        .ADDR_W        (ADDR_W),
        .PIX_PER_LINE  (PIX_PER_LINE),
        .BLANK_LINES   (BLANK_LINES),
        .TOTAL_LINES   (TOTAL_LINES),
        .BYTES_PER_PIX (BYTES_PER_PIX),
        .LINE_W        (LINE_W)
    ) u_start (
        .line_i   (line_nxt),
        .mode_i   (s_q.mode),
        .offset_o (nxt_offset),
        .stride_o (stride)
    );

    always_comb begin
        mode_in = landscape_i ? SCAN_LANDSCAPE : SCAN_PORTRAIT;
        s_d     = s_q;
        if (!s_q.run) begin
            // First edge out of reset: capture frame settings, present pixel 0.
            s_d.run  = 1'b1;
            s_d.mode = mode_in;
            s_d.base = base_i;
            s_d.line = '0;
            s_d.pix  = '0;
            s_d.addr = base_i;
        end else if (addr_ready_i) begin
            if (frame_end) begin
                // Line 0 starts at offset 0 in both orders.
                s_d.mode = mode_in;
                s_d.base = base_i;
                s_d.line = '0;
                s_d.pix  = '0;
                s_d.addr = base_i;
            end else if (last_pix) begin
                s_d.line = line_nxt;
                s_d.pix  = '0;
                s_d.addr = s_q.base + nxt_offset;
            end else begin
                s_d.pix  = pix_nxt;
                s_d.addr = s_q.addr + stride;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{run: 1'b0, mode: SCAN_PORTRAIT, base: '0, line: '0, pix: '0, addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        addr_valid_o = s_q.run;
        addr_o       = s_q.addr;
        sof_o        = s_q.run && (s_q.line == '0) && (s_q.pix == '0);
        eol_o        = s_q.run && last_pix;
    end
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
    parameter int ADDR_W      = 32,
    parameter int LAND_STRIDE = 640,
    parameter int PORT_STRIDE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic              ready,
    input logic [ADDR_W-1:0] addr,
    input logic              sof,
    input logic              eol,
    input logic              land
);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(addr) && $stable(sof) && $stable(eol));

    // R1
    valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

    // R3 R5
    stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && ready && !eol |=>
            addr == $past(addr) + ($past(land) ? ADDR_W'(LAND_STRIDE) : ADDR_W'(PORT_STRIDE)));

    // R9
    sof_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && sof |-> !eol);

    // R2
    eol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && ready && eol |=> !eol);

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !sof |-> $stable(land));
endmodule

bind scan_addr_gen scan_addr_gen_chk #(
    .ADDR_W      (ADDR_W),
    .LAND_STRIDE (VIS_LINES * BYTES_PER_PIX),
    .PORT_STRIDE (BYTES_PER_PIX)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (addr_valid_o),
    .ready (addr_ready_i),
    .addr  (addr_o),
    .sof   (sof_o),
    .eol   (eol_o),
    .land  (s_q.mode == scan_pkg::SCAN_LANDSCAPE)
);

// File: tb/scan_addr_gen_tb.sv
module scan_addr_gen_tb;
    localparam int FRAME_PIX = 240 * 329;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = 32'h0000_1000;
    logic        landscape_i = 1'b0;
    logic        addr_ready_i = 1'b0;
    logic        addr_valid_o;
    logic [31:0] addr_o;
    logic        sof_o;
    logic        eol_o;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model of the scan position
    int          m_line = 0;
    int          m_pix  = 0;
    bit          m_land = 1'b0;
    logic [31:0] m_base = '0;

    always #10 clk = ~clk;

    scan_addr_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_i       (base_i),
        .landscape_i  (landscape_i),
        .addr_ready_i (addr_ready_i),
        .addr_valid_o (addr_valid_o),
        .addr_o       (addr_o),
        .sof_o        (sof_o),
        .eol_o        (eol_o)
    );

    function automatic logic [31:0] exp_addr(int line, int pix, bit land, logic [31:0] base);
        int off;
        if (land) off = ((line < 9) ? 0 : (328 - line) * 2) + pix * 640;
        else      off = (line * 240 + pix) * 2;
        return base + 32'(off);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (line %0d pix %0d)", req, act, exp, m_line, m_pix);
        end
    endtask

    // Compare outputs at the current negedge, then present one cycle of ready.
    task automatic step_cycle(bit rdy);
        string areq;
        if (m_line == 0 && m_pix == 0) areq = "R6 R7 frame start";
        else if (!m_land)              areq = "R3 portrait";
        else if (m_line < 9)           areq = "R4 landscape blank";
        else                           areq = "R5 landscape visible";
        if (!rdy) areq = {areq, " R8 stalled"};
        chk(areq, addr_o, exp_addr(m_line, m_pix, m_land, m_base));
        chk("R8 valid", 32'(addr_valid_o), 32'd1);
        chk("R9 sof", 32'(sof_o), 32'(m_line == 0 && m_pix == 0));
        chk("R2 eol", 32'(eol_o), 32'(m_pix == 239));
        addr_ready_i = rdy;
        @(posedge clk);
        if (rdy) begin
            if (m_pix == 239 && m_line == 328) begin
                m_line = 0; m_pix = 0;
                m_land = landscape_i; m_base = base_i;
            end else if (m_pix == 239) begin
                m_line++; m_pix = 0;
            end else begin
                m_pix++;
            end
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        base_i = 32'h0000_1000;
        landscape_i = 1'b0;
        addr_ready_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 valid in reset", 32'(addr_valid_o), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        m_line = 0; m_pix = 0; m_land = 1'b0; m_base = 32'h0000_1000;
        chk("R1 valid after reset", 32'(addr_valid_o), 32'd1);
        chk("R1 first addr", addr_o, 32'h0000_1000);
        chk("R1 sof", 32'(sof_o), 32'd1);
    endtask

    // Accept n_pix addresses with stalls early on; change frame inputs mid-way (R7).
    task automatic t_frame(int n_pix, int change_at, bit new_land, logic [31:0] new_base);
        for (int k = 0; k < n_pix; k++) begin
            if (k == change_at) begin
                landscape_i = new_land;
                base_i = new_base;
            end
            if (k < 400 && (k % 5) == 2) step_cycle(1'b0);
            step_cycle(1'b1);
        end
    endtask

    initial begin
        t_reset();
        // portrait frame; landscape request arrives mid-frame and must wait
        t_frame(FRAME_PIX, 1000, 1'b1, 32'h0002_0000);
        // landscape frame; portrait request arrives mid-frame
        t_frame(FRAME_PIX, 5000, 1'b0, 32'h0003_0000);
        // start of the following portrait frame
        t_frame(600, -1, 1'b0, 32'h0003_0000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete (got timeout, expected completion)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule